// File: doc/BRIEF.md
# Guarded-Method FIFO with Shared Enqueue

This block is a synchronous first-in first-out store whose pins are grouped into guarded methods. Every operation that needs a condition has a ready output, and every operation that changes state has an enable input. A caller may fire an operation only in a cycle where its ready is high. An enable given while its ready is low is dropped, so the method guard is the block's only form of back-pressure. The operations are: write one element, remove the oldest element, look at the oldest element, empty the store, and a pop that hands out the oldest element and removes it in the same action. The full and empty conditions are also driven as two plain status pins that are valid in every cycle.

Two independent producers share the single write operation. A fixed-priority arbiter inside the block picks one producer per cycle and steers that producer's data into the store. It returns a grant to the chosen producer in the same cycle, so a producer knows at once whether its element was accepted. A producer that gets no grant keeps its enable and data asserted, and retries in the next cycle. Element width and depth are parameters. The pointers wrap at the depth, so the depth does not have to be a power of two.

Top module: `gm_fifo`

## Requirements
- R1: `put_rdy` and `not_full` are high exactly when fewer than DEPTH elements are stored; a full store with no removal and no flush stays full.
- R2: `take_rdy`, `head_rdy` and `pop_rdy` are high exactly when at least one element is stored, and `not_empty` reports the same condition.
- R3: `head_data` always shows the oldest stored element; reading it has no side effect, and elements leave in the order they were written.
- R4: When `pop_en` is high while `pop_rdy` is high, `pop_data` equals the oldest element in that cycle and that element is gone after the next clock edge; `pop_en` and `take_en` together remove only one element.
- R5: `flush_en` empties the store at the next clock edge, and it takes precedence over a write or a removal in the same cycle.
- R6: Producer 0 has priority over producer 1. At most one grant is high. A grant is given only while `put_rdy` is high, and the granted producer's data is the element that gets written.
- R7: A write enable while the store is full, or a removal enable while it is empty, changes no state.
- R8: A write and a removal in the same cycle on a store that is neither full nor empty leave the element count unchanged.
- R9: After reset the store is empty: `not_empty` is 0, `not_full` is 1, and both grants are 0.
- R10: The read and write positions wrap modulo DEPTH, so order is kept over many more than DEPTH elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req0_en | input | 1 | Producer 0 write enable |
| req0_data | input | W | Producer 0 element |
| req0_gnt | output | 1 | Producer 0 write accepted this cycle |
| req1_en | input | 1 | Producer 1 write enable |
| req1_data | input | W | Producer 1 element |
| req1_gnt | output | 1 | Producer 1 write accepted this cycle |
| put_rdy | output | 1 | Write operation ready (not full) |
| take_en | input | 1 | Remove-oldest enable |
| take_rdy | output | 1 | Remove-oldest ready (not empty) |
| head_data | output | W | Oldest element |
| head_rdy | output | 1 | Oldest element valid |
| pop_en | input | 1 | Pop enable |
| pop_rdy | output | 1 | Pop ready (not empty) |
| pop_data | output | W | Element handed out by pop |
| flush_en | input | 1 | Empty the store, always accepted |
| not_full | output | 1 | Status: room for one more element |
| not_empty | output | 1 | Status: at least one element stored |

## Verification
Grants, all ready outputs, `head_data` and `pop_data` are combinational. They are due in the same cycle as the inputs that cause them, so the bench sets inputs one nanosecond after a rising edge and samples one nanosecond later. A write, removal, pop or flush becomes visible only after the next rising edge, so its effect on the status pins and on `head_data` is sampled one nanosecond after that edge. Each scenario task first clears its enables and then checks state, so no stimulus leaks into the next sample.

// File: rtl/gmf_pkg.sv
package gmf_pkg;
  // which producer the shared write port serves this cycle
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_P0   = 2'd1,
    SEL_P1   = 2'd2
  } put_sel_e;

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/gmf_share_arb.sv
module gmf_share_arb
  import gmf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         en0,
  input  logic [W-1:0] d0,
  input  logic         en1,
  input  logic [W-1:0] d1,
  input  logic         slot_free,
  output logic         gnt0,
  output logic         gnt1,
  output logic         put,
  output logic [W-1:0] put_data
);
  put_sel_e sel;

  // fixed priority: producer 0 first, nobody when no room
  always_comb begin
    sel = SEL_NONE;
    if (slot_free) begin
      if (en0)      sel = SEL_P0;
      else if (en1) sel = SEL_P1;
    end
  end

  assign gnt0 = (sel == SEL_P0);
  assign gnt1 = (sel == SEL_P1);
  assign put  = gnt0 | gnt1;

  always_comb begin
    unique case (sel)
      SEL_P1:  put_data = d1;
      default: put_data = d0;
    endcase
  end
endmodule

// File: rtl/gmf_ring.sv
module gmf_ring
  import gmf_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         put,
  input  logic [W-1:0]                 put_data,
  input  logic                         drop,
  input  logic                         wipe,
  output logic [W-1:0]                 oldest,
  output logic [$clog2(DEPTH+1)-1:0]   occ,
  output logic                         is_full,
  output logic                         is_empty
);
  localparam int PTR_W = ptr_bits(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (put) slots[wr_ptr] <= put_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (wipe) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (put)  wr_ptr <= step(wr_ptr);
      if (drop) rd_ptr <= step(rd_ptr);
      unique case ({put, drop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign oldest   = slots[rd_ptr];
  assign occ      = cnt;
  assign is_full  = (cnt == CNT_W'(DEPTH));
  assign is_empty = (cnt == '0);
endmodule

// File: rtl/gm_fifo.sv
module gm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req0_en,
  input  logic [W-1:0] req0_data,
  output logic         req0_gnt,
  input  logic         req1_en,
  input  logic [W-1:0] req1_data,
  output logic         req1_gnt,
  output logic         put_rdy,
  input  logic         take_en,
  output logic         take_rdy,
  output logic [W-1:0] head_data,
  output logic         head_rdy,
  input  logic         pop_en,
  output logic         pop_rdy,
  output logic [W-1:0] pop_data,
  input  logic         flush_en,
  output logic         not_full,
  output logic         not_empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic         put;
  logic [W-1:0] put_data;
  logic         drop;
  logic         is_full, is_empty;
  logic [W-1:0] oldest;
  logic [CNT_W-1:0] occ;

  assign not_full  = ~is_full;
  assign not_empty = ~is_empty;

  gmf_share_arb #(.W(W)) u_arb (
    .en0      (req0_en),
    .d0       (req0_data),
    .en1      (req1_en),
    .d1       (req1_data),
    .slot_free(not_full),
    .gnt0     (req0_gnt),
    .gnt1     (req1_gnt),
    .put      (put),
    .put_data (put_data)
  );

  // take and pop share one removal; guarded by not_empty
  assign drop = (take_en | pop_en) & not_empty;

  gmf_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .put     (put),
    .put_data(put_data),
    .drop    (drop),
    .wipe    (flush_en),
    .oldest  (oldest),
    .occ     (occ),
    .is_full (is_full),
    .is_empty(is_empty)
  );

  assign put_rdy   = not_full;
  assign take_rdy  = not_empty;
  assign head_rdy  = not_empty;
  assign pop_rdy   = not_empty;
  assign head_data = oldest;
  assign pop_data  = oldest;
endmodule

// File: rtl/gm_fifo_chk.sv
module gm_fifo_chk #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req0_en,
  input logic                       req0_gnt,
  input logic                       req1_gnt,
  input logic                       put_rdy,
  input logic                       take_en,
  input logic                       pop_en,
  input logic                       pop_rdy,
  input logic [W-1:0]               pop_data,
  input logic [W-1:0]               head_data,
  input logic                       flush_en,
  input logic                       not_full,
  input logic                       not_empty,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req0_gnt, req1_gnt}));

  assert_grant_needs_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !put_rdy |-> !(req0_gnt || req1_gnt));

  assert_p0_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req0_en && put_rdy) |-> req0_gnt);

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> (!not_empty && not_full));

  assert_full_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_full && !take_en && !pop_en && !flush_en) |=> !not_full);

  assert_empty_remove_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && !req0_gnt && !req1_gnt && !flush_en) |=> !not_empty);

  assert_pop_gives_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && pop_rdy) |-> (pop_data == head_data));

  assert_swap_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((req0_gnt || req1_gnt) && (take_en || pop_en) && not_empty && !flush_en)
      |=> (occ == $past(occ)));
endmodule

bind gm_fifo gm_fifo_chk #(.W(W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_gm_fifo.sv
`timescale 1ns/1ps
module sim_gm_fifo;
  localparam int W = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req0_en = 0, req1_en = 0, take_en = 0, pop_en = 0, flush_en = 0;
  logic [W-1:0] req0_data = '0, req1_data = '0;
  logic req0_gnt, req1_gnt, put_rdy, take_rdy, head_rdy, pop_rdy, not_full, not_empty;
  logic [W-1:0] head_data, pop_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gm_fifo #(.W(W), .DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    req0_en = 0; req1_en = 0; take_en = 0; pop_en = 0; flush_en = 0;
  endtask

  task automatic put0(input logic [W-1:0] d);
    req0_en = 1; req0_data = d; #1;
    chk("R6 p0 grant", int'(req0_gnt), 1);
    tick(); idle();
  endtask

  task automatic take_expect(input logic [W-1:0] d, input string req);
    take_en = 1; #1;
    chk(req, int'(head_data), int'(d));
    tick(); idle();
  endtask

  task automatic t_reset();
    #1;
    chk("R9 not_empty", int'(not_empty), 0);
    chk("R9 not_full", int'(not_full), 1);
    chk("R9 grants", int'({req0_gnt, req1_gnt}), 0);
    chk("R2 ready low when empty", int'({take_rdy, head_rdy, pop_rdy}), 0);
    chk("R1 put_rdy", int'(put_rdy), 1);
  endtask

  task automatic t_fill_full();
    for (int i = 0; i < DEPTH; i++) put0(8'hA0 + 8'(i));
    chk("R1 put_rdy when full", int'(put_rdy), 0);
    chk("R1 not_full when full", int'(not_full), 0);
    req1_en = 1; req1_data = 8'hEE; #1;
    chk("R6 no grant when full", int'(req1_gnt), 0);
    tick(); idle(); #1;
    chk("R7 full write ignored", int'(head_data), 8'hA0);
    chk("R1 stays full", int'(not_full), 0);
    for (int i = 0; i < DEPTH; i++) take_expect(8'hA0 + 8'(i), "R3 order");
    chk("R2 empty after drain", int'(not_empty), 0);
  endtask

  task automatic t_empty_remove();
    take_en = 1; pop_en = 1; tick(); idle();
    chk("R7 still empty", int'(not_empty), 0);
    put0(8'h5A);
    chk("R2 ready after write", int'({take_rdy, head_rdy, pop_rdy}), 7);
    chk("R7 count not corrupted", int'(head_data), 8'h5A);
    take_expect(8'h5A, "R7 single entry");
    chk("R7 empty again", int'(not_empty), 0);
  endtask

  task automatic t_arbitrate();
    req0_en = 1; req0_data = 8'h11; req1_en = 1; req1_data = 8'h22; #1;
    chk("R6 p0 priority gnt0", int'(req0_gnt), 1);
    chk("R6 p0 priority gnt1", int'(req1_gnt), 0);
    tick(); req0_en = 0; #1;
    chk("R6 p1 served alone", int'(req1_gnt), 1);
    tick(); idle();
    take_expect(8'h11, "R6 p0 data first");
    take_expect(8'h22, "R6 p1 data second");
  endtask

  task automatic t_pop();
    put0(8'h55); put0(8'h66); put0(8'h77);
    pop_en = 1; #1;
    chk("R4 pop_rdy", int'(pop_rdy), 1);
    chk("R4 pop data", int'(pop_data), 8'h55);
    tick(); idle(); #1;
    chk("R4 removed", int'(head_data), 8'h66);
    pop_en = 1; take_en = 1; tick(); idle(); #1;
    chk("R4 pop+take removes one", int'(head_data), 8'h77);
    take_expect(8'h77, "R4 last");
  endtask

  task automatic t_swap();
    put0(8'h81);
    req0_en = 1; req0_data = 8'h82; take_en = 1; tick(); idle(); #1;
    chk("R8 head after swap", int'(head_data), 8'h82);
    chk("R8 still one entry", int'(not_empty), 1);
    take_en = 1; tick(); idle(); #1;
    chk("R8 one entry only", int'(not_empty), 0);
  endtask

  task automatic t_flush();
    put0(8'h91); put0(8'h92);
    flush_en = 1; req0_en = 1; req0_data = 8'h93; take_en = 1;
    tick(); idle(); #1;
    chk("R5 empty after flush", int'(not_empty), 0);
    chk("R5 not_full after flush", int'(not_full), 1);
  endtask

  task automatic t_wrap();
    put0(8'hC0);
    put0(8'hC1);
    for (int i = 2; i < 12; i++) begin
      req0_en = 1; req0_data = 8'hC0 + 8'(i); take_en = 1; #1;
      chk("R10 wrap order", int'(head_data), int'(8'hC0 + 8'(i - 2)));
      tick(); idle();
    end
    take_expect(8'hCA, "R10 tail a");
    take_expect(8'hCB, "R10 tail b");
    chk("R10 empty", int'(not_empty), 0);
  endtask

  initial begin
    #7 rst_n = 1'b1;
    tick();
    t_reset();
    t_fill_full();
    t_empty_remove();
    t_arbitrate();
    t_pop();
    t_swap();
    t_flush();
    t_wrap();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule